// File: doc/BRIEF.md
# Host Controller Command and Interrupt Status Registers

This block is the command/status and interrupt-status register pair of an embedded bus host controller. Software reaches both registers through an 8-bit command code: the top bit of the code picks a write (1) or a read (0), and the low seven bits pick the register. The command/status register carries a software reset request and a 2-bit scheduling-overrun event counter. The interrupt status register holds one sticky flag per hardware event. Hardware sets a flag and software clears it by writing a one.

A software reset request starts a bounded reset sequence. The sequence is a counter of a configurable number of clock cycles, sized so that it ends well inside 10 µs at the chosen clock. While it runs, the block drives a reset strobe to the operational registers. It also clears its own flags and counter, refuses register accesses, and afterwards reports the suspend functional state. The root hub and the downstream ports sit outside this block and receive nothing from the sequence. The interrupt request is a registered level signal. It combines the pending flags with a per-event enable mask and a master enable.

Top module: `hc_cmd_irq_regs`

## Requirements
- R1: A command with code bit 7 set is a write and one with bit 7 clear is a read. Register number 02h is command/status (codes 02h/82h) and 03h is interrupt status (codes 03h/83h). Read data appears on `rd_data` in the cycle after the read command. Reads of any other register number return zero, and writes to them change nothing.
- R2: The command/status word has the reset request at bit 0 and the overrun count at bits 17:16. All other bits read as zero. Writing bits other than bit 0 has no effect, and writing 0 to bit 0 starts nothing.
- R3: The overrun count resets to 0. It increments by one on every cycle in which `evt_pulse[0]` (the scheduling-overrun event) is high, and it wraps from 3 to 0. It keeps counting while interrupt status bit 0 is already set.
- R4: Writing 1 to bit 0 of the command/status register raises `op_reset` in the next cycle. `op_reset` stays high for exactly RST_CYCLES consecutive cycles, and `fs_suspend` rises with it and stays high.
- R5: While `op_reset` is high, register writes, including a new reset request, are ignored, reads return zero, and event pulses are ignored. When the sequence ends, all interrupt status bits and the overrun count are zero.
- R6: Interrupt status bit i is set when `evt_pulse[i]` is high. Writing 1 to bit i of register 03h clears it, writing 0 leaves it unchanged, and software can never set a bit. Register 03h reads the flags in bits NUM_EVT-1:0 and zero above them.
- R7: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is high in the cycle after any flag whose `irq_enable` bit is set is pending while `master_irq_en` is high. It is low otherwise.
- R9: After the hardware reset, all register contents read zero, and `irq`, `op_reset` and `fs_suspend` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cmd_valid | input | 1 | Register access command this cycle |
| cmd_code | input | 8 | Command code: bit 7 write, bits 6:0 register number |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered |
| evt_pulse | input | NUM_EVT | Hardware event pulses, bit 0 is scheduling overrun |
| irq_enable | input | NUM_EVT | Per-event interrupt enable mask |
| master_irq_en | input | 1 | Master interrupt enable |
| irq | output | 1 | Interrupt request level |
| fs_suspend | output | 1 | Functional state is suspend after a software reset |
| op_reset | output | 1 | Reset strobe to operational registers during the sequence |

## Verification
The bench builds the block with NUM_EVT = 7 and RST_CYCLES = 12. Seven events keep every flag pattern within a 128-step sweep, and that sweep exercises set, write-1 clear, write-0, same-cycle set-versus-clear and the interrupt mask for each pattern. A 12-cycle sequence lets the bench count the whole reset window cycle by cycle. It also places reads, writes, a second reset request and events inside that window. All 256 command codes are swept for decode, and the overrun count is driven through more than two full wraps with its flag held set.

// File: rtl/hc_regs_pkg.sv
// Package: shared constants and register selector for the host controller
// command/interrupt register block.
// Assumes register numbers are the low seven bits of the command code.
package hc_regs_pkg;

    localparam logic [6:0] REGNUM_CMDSTAT = 7'h02;
    localparam logic [6:0] REGNUM_IRQSTAT = 7'h03;

    localparam int CS_RESET_BIT = 0;   // reset request position
    localparam int CS_SOC_LSB   = 16;  // overrun count field base
    localparam int OVR_EVT_IDX  = 0;   // event index of scheduling overrun

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_CMDSTAT = 2'd1,
        SEL_IRQSTAT = 2'd2
    } reg_sel_e;

    // Map a register number to a selector.
    function automatic reg_sel_e decode_sel(input logic [6:0] regnum);
        if (regnum == REGNUM_CMDSTAT)      return SEL_CMDSTAT;
        else if (regnum == REGNUM_IRQSTAT) return SEL_IRQSTAT;
        else                               return SEL_NONE;
    endfunction

endpackage

// File: rtl/hc_reset_seq.sv
// Module: hc_reset_seq
// Counts a software reset sequence of RST_CYCLES clock cycles. busy is high
// for exactly that many cycles after a start pulse. A start while busy is
// ignored. fs_suspend latches high at the first start.
// Assumes RST_CYCLES >= 1 and start is a single-cycle request.
module hc_reset_seq #(
    parameter int RST_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fs_suspend
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] remain;

    // Load, count down and end the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - CW'(1);
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(RST_CYCLES - 1);
        end
    end

    // Record entry to the suspend functional state.
    always_ff @(posedge clk) begin
        if (!rst_n)     fs_suspend <= 1'b0;
        else if (start) fs_suspend <= 1'b1;
    end

endmodule

// File: rtl/hc_event_flags.sv
// Module: hc_event_flags
// Sticky event flags. Hardware sets them, and software clears them with a
// write-1 mask. A set wins over a same-cycle clear. Also forms the
// registered interrupt level.
// Assumes hold_clear holds every flag at zero and drops events.
module hc_event_flags #(
    parameter int NUM_EVT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_clear,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] clr_mask,
    input  logic [NUM_EVT-1:0] enable,
    input  logic               master_en,
    output logic [NUM_EVT-1:0] flags,
    output logic               irq
);
    // Per-bit flag update; set has priority over clear.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || hold_clear) flags[i] <= 1'b0;
            else if (evt[i])          flags[i] <= 1'b1;
            else if (clr_mask[i])     flags[i] <= 1'b0;
        end
    end

    // Registered interrupt request from pending, enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= master_en && (|(flags & enable));
    end

endmodule

// File: rtl/hc_overrun_cnt.sv
// Module: hc_overrun_cnt
// Wrapping counter of scheduling-overrun events, independent of the sticky
// flag for the same event.
// Assumes inc is a one-cycle pulse per event.
module hc_overrun_cnt #(
    parameter int SOC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clear,
    input  logic             inc,
    output logic [SOC_W-1:0] count
);
    // Count events, wrapping at the field width.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clear) count <= '0;
        else if (inc)             count <= count + SOC_W'(1);
    end

endmodule

// File: rtl/hc_cmd_irq_regs.sv
// Module: hc_cmd_irq_regs (top)
// Command/status and interrupt-status registers behind a command-code
// interface. Decodes reads and writes, runs the software reset sequence,
// keeps the overrun count and the sticky flags, and drives the interrupt.
// Assumes DATA_W > CS_SOC_LSB + SOC_W and NUM_EVT < DATA_W.
module hc_cmd_irq_regs
    import hc_regs_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_EVT    = 7,
    parameter int SOC_W      = 2,
    parameter int RST_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_code,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [NUM_EVT-1:0] irq_enable,
    input  logic               master_irq_en,
    output logic               irq,
    output logic               fs_suspend,
    output logic               op_reset
);
    reg_sel_e           sel;
    logic               cmd_wr;
    logic               cmd_rd;
    logic               busy;
    logic               rst_start;
    logic [NUM_EVT-1:0] clr_mask;
    logic [NUM_EVT-1:0] flags;
    logic [SOC_W-1:0]   soc;
    logic [DATA_W-1:0]  cs_word;
    logic [DATA_W-1:0]  is_word;
    logic               unused_wr_hi;

    assign sel    = decode_sel(cmd_code[6:0]);
    assign cmd_wr = cmd_valid &&  cmd_code[7];
    assign cmd_rd = cmd_valid && !cmd_code[7];

    assign rst_start = cmd_wr && !busy && (sel == SEL_CMDSTAT)
                       && wr_data[CS_RESET_BIT];
    assign clr_mask  = (cmd_wr && !busy && (sel == SEL_IRQSTAT))
                       ? wr_data[NUM_EVT-1:0] : '0;
    assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_EVT];

    hc_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rst_start),
        .busy       (busy),
        .fs_suspend (fs_suspend)
    );

    hc_event_flags #(.NUM_EVT(NUM_EVT)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (busy),
        .evt        (evt_pulse),
        .clr_mask   (clr_mask),
        .enable     (irq_enable),
        .master_en  (master_irq_en),
        .flags      (flags),
        .irq        (irq)
    );

    hc_overrun_cnt #(.SOC_W(SOC_W)) u_soc (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (busy),
        .inc        (evt_pulse[OVR_EVT_IDX]),
        .count      (soc)
    );

    // Assemble the command/status word; reserved bits stay zero.
    always_comb begin
        cs_word = '0;
        cs_word[CS_RESET_BIT] = busy;
        cs_word[CS_SOC_LSB +: SOC_W] = soc;
    end

    // Assemble the interrupt status word.
    always_comb begin
        is_word = '0;
        is_word[NUM_EVT-1:0] = flags;
    end

    // Register read data; zero while resetting or for unknown registers.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (cmd_rd) begin
            if (busy)                     rd_data <= '0;
            else if (sel == SEL_CMDSTAT)  rd_data <= cs_word;
            else if (sel == SEL_IRQSTAT)  rd_data <= is_word;
            else                          rd_data <= '0;
        end
    end

    assign op_reset = busy;

endmodule

// File: rtl/hc_regs_chk.sv
// Module: hc_regs_chk
// Property checker for hc_cmd_irq_regs, attached with bind below.
// Measures the reset window with its own counter.
module hc_regs_chk #(
    parameter int DATA_W     = 32,
    parameter int NUM_EVT    = 7,
    parameter int SOC_W      = 2,
    parameter int RST_CYCLES = 1000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [7:0]         cmd_code,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               master_irq_en,
    input logic               irq,
    input logic               op_reset,
    input logic [NUM_EVT-1:0] flags,
    input logic [SOC_W-1:0]   soc
);
    localparam int RW = $clog2(RST_CYCLES + 2);

    logic [RW-1:0] run;

    // Length of the current op_reset window so far.
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= '0;
        else if (op_reset) run <= run + RW'(1);
        else               run <= '0;
    end

    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        op_reset |-> (run < RW'(RST_CYCLES)));

    a_r4_window_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(op_reset) |-> (run == RW'(RST_CYCLES)));

    a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_reset && cmd_valid && !cmd_code[7]) |=> (rd_data == '0));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[0] && !op_reset) |=> (soc == $past(soc) + SOC_W'(1)));

    a_r6_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(evt_pulse)) == '0));

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !op_reset |=> (($past(evt_pulse) & ~flags) == '0));

    a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !master_irq_en |=> !irq);

endmodule

bind hc_cmd_irq_regs hc_regs_chk #(
    .DATA_W     (DATA_W),
    .NUM_EVT    (NUM_EVT),
    .SOC_W      (SOC_W),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .rd_data       (rd_data),
    .evt_pulse     (evt_pulse),
    .master_irq_en (master_irq_en),
    .irq           (irq),
    .op_reset      (op_reset),
    .flags         (flags),
    .soc           (soc)
);

// File: tb/tb_hc_cmd_irq_regs.sv
`timescale 1ns/1ps
// Bench for hc_cmd_irq_regs: sweeps flag patterns, command codes and the
// reset window, with expected values worked out in the bench.
module tb_hc_cmd_irq_regs;
    localparam int DW   = 32;
    localparam int NE   = 7;
    localparam int RSTC = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [7:0]    cmd_code;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic [NE-1:0] evt_pulse;
    logic [NE-1:0] irq_enable;
    logic          master_irq_en;
    logic          irq;
    logic          fs_suspend;
    logic          op_reset;

    int            n_chk = 0;
    int            n_bad = 0;
    logic [1:0]    soc_m = 2'd0;
    logic [NE-1:0] fl_m  = '0;

    always #4 clk = ~clk;

    hc_cmd_irq_regs #(.DATA_W(DW), .NUM_EVT(NE), .SOC_W(2), .RST_CYCLES(RSTC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
        .irq_enable(irq_enable), .master_irq_en(master_irq_en), .irq(irq),
        .fs_suspend(fs_suspend), .op_reset(op_reset)
    );

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One clock cycle with the given inputs; call just after a negedge.
    task automatic cyc(input logic v, input logic [7:0] code, input logic [DW-1:0] d,
                       input logic [NE-1:0] e);
        cmd_valid = v; cmd_code = code; wr_data = d; evt_pulse = e;
        if (e[0]) soc_m = soc_m + 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = '0; wr_data = '0; evt_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] code, output logic [DW-1:0] val);
        cyc(1'b1, code, '0, '0);
        val = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int            hi;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; wr_data = '0;
        evt_pulse = '0; irq_enable = '0; master_irq_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: state after hardware reset
        chk("R9 irq", {31'b0, irq}, 0);
        chk("R9 op_reset", {31'b0, op_reset}, 0);
        chk("R9 fs_suspend", {31'b0, fs_suspend}, 0);
        rd(8'h02, v); chk("R9 cmdstat", v, 0);
        rd(8'h03, v); chk("R9 irqstat", v, 0);

        // R6 R7 R8: sweep every flag pattern
        for (int p = 0; p < 128; p++) begin
            logic [NE-1:0] pp, c1, c2, q, en;
            logic          m;
            pp = NE'(p);
            c1 = NE'(p * 37 + 11);
            c2 = NE'(p * 91);
            q  = NE'(p * 5 + 3);
            en = NE'(p * 13 + 7);
            m  = pp[1];
            cyc(1'b1, 8'h83, 32'h7F, '0);
            cyc(1'b0, 8'h00, '0, pp);
            rd(8'h03, v); chk("R6 set by event", v, {25'b0, pp});
            cyc(1'b1, 8'h83, {25'h1FFFFFF, c1}, '0);
            fl_m = pp & ~c1;
            rd(8'h03, v); chk("R6 write-1 clear, write-0 keep", v, {25'b0, fl_m});
            cyc(1'b1, 8'h83, {25'b0, c2}, q);
            fl_m = (fl_m & ~c2) | q;
            rd(8'h03, v); chk("R7 set wins over clear", v, {25'b0, fl_m});
            irq_enable = en; master_irq_en = m;
            @(negedge clk);
            chk("R8 irq level", {31'b0, irq}, {31'b0, m && |(fl_m & en)});
        end
        irq_enable = '0; master_irq_en = 1'b0;

        // R1: decode of all command codes
        cyc(1'b1, 8'h83, 32'h7F, '0);
        cyc(1'b0, 8'h00, '0, 7'h7F);
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cc;
            cc = 8'(c);
            if (cc == 8'h82 || cc == 8'h83) continue;
            if (cc[7]) begin
                cyc(1'b1, cc, 32'hFFFF_FFFF, '0);
                rd(8'h03, v); chk("R1 stray write ignored", v, 32'h7F);
            end else begin
                rd(cc, v);
                if (cc == 8'h02)      chk("R1 read cmdstat", v, {14'b0, soc_m, 16'b0});
                else if (cc == 8'h03) chk("R1 read irqstat", v, 32'h7F);
                else                  chk("R1 unknown read zero", v, 0);
            end
        end

        // R2: writes to non-reset bits have no effect
        cyc(1'b1, 8'h82, 32'hFFFF_FFFE, '0);
        chk("R2 no reset on bit0=0", {31'b0, op_reset}, 0);
        rd(8'h02, v); chk("R2 layout unchanged", v, {14'b0, soc_m, 16'b0});

        // R3: count wraps and keeps counting with its flag set
        for (int n = 0; n < 9; n++) begin
            cyc(1'b0, 8'h00, '0, 7'h01);
            rd(8'h02, v); chk("R3 overrun count", v, {14'b0, soc_m, 16'b0});
        end
        rd(8'h03, v); chk("R3 flag still set", v & 32'h1, 32'h1);

        // R4 R5: reset window
        cyc(1'b1, 8'h82, 32'h1, '0);
        chk("R4 fs_suspend set", {31'b0, fs_suspend}, 1);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            if (op_reset) hi++;
            if (i == 2) chk("R5 read zero during reset", rd_data, 0);
            cmd_valid = (i == 1) || (i == 2) || (i == 4);
            cmd_code  = (i == 1) ? 8'h03 : (i == 2) ? 8'h82 : 8'h83;
            wr_data   = (i == 2) ? 32'h1 : 32'h0;
            evt_pulse = (i == 3) ? 7'h7F : 7'h00;
            @(negedge clk);
            cmd_valid = 1'b0; cmd_code = '0; wr_data = '0; evt_pulse = '0;
        end
        chk("R4 window length", 32'(hi), 32'(RSTC));
        soc_m = 2'd0;
        rd(8'h03, v); chk("R5 flags cleared", v, 0);
        rd(8'h02, v); chk("R5 count cleared", v, 0);
        chk("R4 fs_suspend held", {31'b0, fs_suspend}, 1);
        cyc(1'b0, 8'h00, '0, 7'h04);
        rd(8'h03, v); chk("R6 flags live after reset", v, 32'h4);

        summary();
        $finish;
    end
endmodule